// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Unit

This block keeps the interrupt status of a four-channel DMA controller. Each channel's transfer engine sends one-cycle pulses when a transfer finishes, when it reaches the halfway point, or when it hits an error. The block records each pulse in a sticky flag. From each channel's three enable bits it forms one interrupt line per channel.

Software reads every flag through one packed 32-bit status register. It clears chosen flags by writing ones to a separate clear register. Each channel has a nibble in the status word. The lowest bit of the nibble is a summary flag that is set whenever any of the channel's three event flags is set. Register reads are combinational from the address. Writes take effect on the next rising clock edge.

Top module: `dma_irq_flags`

## Requirements
- R1: After active-low reset, every flag is zero, the status word reads 0 and all interrupt lines are low, whatever the enable inputs are.
- R2: A set pulse on a channel's event input sets that flag at the next rising edge. The flag stays set until it is cleared, whatever its enable bit. In status nibble n (bits 4n+3..4n), the finish flag is at bit 4n+1, the halfway flag at 4n+2 and the error flag at 4n+3.
- R3: Status bit 4n reads 1 exactly when at least one of channel n's three event flags is set. Status bits 31..16 read 0.
- R4: Interrupt line n is the OR of three terms: the finish flag AND its enable, the halfway flag AND its enable, and the error flag AND its enable. A change of enable takes effect in the same cycle.
- R5: A write to byte offset 0x84 with a 1 in bit 4n+1, 4n+2 or 4n+3 clears channel n's finish, halfway or error flag at the next edge. Zero bits and bit 4n leave every flag unchanged.
- R6: If a set pulse and a clear bit hit the same flag in the same cycle, the flag ends up set.
- R7: A read at byte offset 0x80 returns the status word. A read at 0x84 or at any other offset returns 0. Writes to 0x80 or to any offset other than 0x84 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setDone | input | 4 | Per-channel transfer-finished set pulses |
| setHalf | input | 4 | Per-channel halfway set pulses |
| setErr | input | 4 | Per-channel error set pulses |
| enDone | input | 4 | Per-channel finish interrupt enables |
| enHalf | input | 4 | Per-channel halfway interrupt enables |
| enErr | input | 4 | Per-channel error interrupt enables |
| regAddr | input | 8 | Register byte offset |
| regWrite | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
For every channel and every event type, the bench sets that single flag and then steps through all eight enable combinations of the channel. This tells whether the interrupt line uses the right enable, and whether a flag leaks into a neighbouring channel or into the wrong nibble bit. For every channel it also sweeps all sixteen clear patterns over a fully set status word. That shows that the clear targets exactly the matching bits, and that the summary bit in the clear pattern is ignored. The remaining cases are writes to the status offset and to an unused offset, a read of the clear offset, and set and clear arriving in the same cycle. Together these separate the write-one-to-clear path from stray writes, and they fix the set-over-clear priority.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  parameter int CH_COUNT = 4;
  parameter int ADDR_W   = 8;
  parameter int DATA_W   = 32;
  parameter logic [ADDR_W-1:0] STATUS_OFF = 8'h80;
  parameter logic [ADDR_W-1:0] CLEAR_OFF  = 8'h84;
  localparam int GRP_W  = 4;
  localparam int USED_W = GRP_W * CH_COUNT;

  typedef struct packed {
    logic [CH_COUNT-1:0] clrDone;
    logic [CH_COUNT-1:0] clrHalf;
    logic [CH_COUNT-1:0] clrErr;
  } clrStrobe_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] regRdata,
  output clrStrobe_t        strobes
);
  logic clearHit;
  logic unusedWdata;

  assign clearHit    = regWrite && (regAddr == CLEAR_OFF);
  assign unusedWdata = ^regWdata;

  for (genvar n = 0; n < CH_COUNT; n++) begin : g_clr
    assign strobes.clrDone[n] = clearHit & regWdata[GRP_W*n + 1];
    assign strobes.clrHalf[n] = clearHit & regWdata[GRP_W*n + 2];
    assign strobes.clrErr[n]  = clearHit & regWdata[GRP_W*n + 3];
  end

  always_comb begin
    if (regAddr == STATUS_OFF) regRdata = statusWord;
    else                       regRdata = '0;
  end
endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] setDone,
  input  logic [CH_COUNT-1:0] setHalf,
  input  logic [CH_COUNT-1:0] setErr,
  input  logic [CH_COUNT-1:0] enDone,
  input  logic [CH_COUNT-1:0] enHalf,
  input  logic [CH_COUNT-1:0] enErr,
  input  clrStrobe_t          strobes,
  output logic [DATA_W-1:0]   statusWord,
  output logic [CH_COUNT-1:0] irq
);
  logic [CH_COUNT-1:0] doneFlag, halfFlag, errFlag;

  for (genvar n = 0; n < CH_COUNT; n++) begin : g_ch
    // set is ORed after the clear mask, so a set pulse wins over a clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        doneFlag[n] <= 1'b0;
        halfFlag[n] <= 1'b0;
        errFlag[n]  <= 1'b0;
      end else begin
        doneFlag[n] <= (doneFlag[n] & ~strobes.clrDone[n]) | setDone[n];
        halfFlag[n] <= (halfFlag[n] & ~strobes.clrHalf[n]) | setHalf[n];
        errFlag[n]  <= (errFlag[n]  & ~strobes.clrErr[n])  | setErr[n];
      end
    end

    assign statusWord[GRP_W*n +: GRP_W] =
      {errFlag[n], halfFlag[n], doneFlag[n], doneFlag[n] | halfFlag[n] | errFlag[n]};

    assign irq[n] = (enDone[n] & doneFlag[n]) |
                    (enHalf[n] & halfFlag[n]) |
                    (enErr[n]  & errFlag[n]);
  end

  if (USED_W < DATA_W) begin : g_pad
    assign statusWord[DATA_W-1:USED_W] = '0;
  end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [CH_COUNT-1:0] setDone,
  input  logic [CH_COUNT-1:0] setHalf,
  input  logic [CH_COUNT-1:0] setErr,
  input  logic [CH_COUNT-1:0] enDone,
  input  logic [CH_COUNT-1:0] enHalf,
  input  logic [CH_COUNT-1:0] enErr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrite,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic [CH_COUNT-1:0] irq
);
  clrStrobe_t        strobes;
  logic [DATA_W-1:0] statusWord;

  dma_irq_ctrl u_ctrl (
    .regAddr(regAddr), .regWrite(regWrite), .regWdata(regWdata),
    .statusWord(statusWord), .regRdata(regRdata), .strobes(strobes)
  );

  dma_irq_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .setDone(setDone), .setHalf(setHalf), .setErr(setErr),
    .enDone(enDone), .enHalf(enHalf), .enErr(enErr),
    .strobes(strobes), .statusWord(statusWord), .irq(irq)
  );
endmodule

// File: rtl/dma_irq_flags_chk.sv
module dma_irq_flags_chk
  import dma_irq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [CH_COUNT-1:0] setDone,
  input logic [CH_COUNT-1:0] setHalf,
  input logic [CH_COUNT-1:0] setErr,
  input logic [CH_COUNT-1:0] enDone,
  input logic [CH_COUNT-1:0] enHalf,
  input logic [CH_COUNT-1:0] enErr,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrite,
  input logic [DATA_W-1:0]   regWdata,
  input logic [DATA_W-1:0]   regRdata,
  input logic [DATA_W-1:0]   statusWord,
  input logic [CH_COUNT-1:0] irq
);
  logic clrWr;
  logic [3*CH_COUNT-1:0] setCat;
  assign clrWr  = regWrite && (regAddr == CLEAR_OFF);
  assign setCat = {setErr, setHalf, setDone};

  for (genvar n = 0; n < CH_COUNT; n++) begin : g_ch
    for (genvar e = 0; e < 3; e++) begin : g_ev
      localparam int B = GRP_W*n + 1 + e;
      // R2: set pulse lands in the flag
      a_r2_set_lands: assert property (@(posedge clk) disable iff (!rstN)
        setCat[e*CH_COUNT + n] |=> statusWord[B]);
      // R2: a set flag stays set without a clear bit
      a_r2_sticky: assert property (@(posedge clk) disable iff (!rstN)
        (statusWord[B] && !(clrWr && regWdata[B])) |=> statusWord[B]);
      // R5: a clear bit without a set pulse drops the flag
      a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
        (clrWr && regWdata[B] && !setCat[e*CH_COUNT + n]) |=> !statusWord[B]);
      // R5 / R7: no flag rises without a set pulse
      a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
        (!statusWord[B] && !setCat[e*CH_COUNT + n]) |=> !statusWord[B]);
    end
    // R3: summary bit tracks the event flags
    a_r3_summary: assert property (@(posedge clk) disable iff (!rstN)
      statusWord[GRP_W*n] == (|statusWord[GRP_W*n+1 +: 3]));
    // R4: interrupt line masked by enables
    a_r4_irq: assert property (@(posedge clk) disable iff (!rstN)
      irq[n] == ((enDone[n] & statusWord[GRP_W*n+1]) |
                 (enHalf[n] & statusWord[GRP_W*n+2]) |
                 (enErr[n]  & statusWord[GRP_W*n+3])));
  end

  // R7: reads away from the status offset return zero
  a_r7_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != STATUS_OFF) |-> (regRdata == '0));
  // R3: unused status bits read zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[DATA_W-1:USED_W] == '0);
endmodule

bind dma_irq_flags dma_irq_flags_chk u_chk (
  .clk(clk), .rstN(rstN), .setDone(setDone), .setHalf(setHalf), .setErr(setErr),
  .enDone(enDone), .enHalf(enHalf), .enErr(enErr), .regAddr(regAddr),
  .regWrite(regWrite), .regWdata(regWdata), .regRdata(regRdata),
  .statusWord(statusWord), .irq(irq)
);

// File: tb/dma_irq_flags_bench.sv
module dma_irq_flags_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] setDone = '0, setHalf = '0, setErr = '0;
  logic [3:0] enDone = '0, enHalf = '0, enErr = '0;
  logic [7:0] regAddr = 8'h80;
  logic regWrite = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0] irq;

  logic [3:0] mDone = '0, mHalf = '0, mErr = '0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_irq_flags u_dma_irq_flags (
    .clk(clk), .rstN(rstN), .setDone(setDone), .setHalf(setHalf), .setErr(setErr),
    .enDone(enDone), .enHalf(enHalf), .enErr(enErr), .regAddr(regAddr),
    .regWrite(regWrite), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  function automatic logic [31:0] expStatus();
    logic [31:0] s = '0;
    for (int n = 0; n < 4; n++)
      s[4*n +: 4] = {mErr[n], mHalf[n], mDone[n], mDone[n] | mHalf[n] | mErr[n]};
    return s;
  endfunction

  function automatic logic [3:0] expIrq();
    return (enDone & mDone) | (enHalf & mHalf) | (enErr & mErr);
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    regAddr = 8'h80;
    #1;
    checkEq({tag, " status"}, regRdata, expStatus());
    checkEq({tag, " irq"}, {28'b0, irq}, {28'b0, expIrq()});
  endtask

  task automatic applyCycle(input logic [3:0] sD, input logic [3:0] sH, input logic [3:0] sE,
                            input logic wr, input logic [7:0] addr, input logic [31:0] data,
                            input string tag);
    logic [3:0] cD, cH, cE;
    setDone = sD; setHalf = sH; setErr = sE;
    regWrite = wr; regAddr = addr; regWdata = data;
    @(posedge clk); #1;
    cD = '0; cH = '0; cE = '0;
    if (wr && addr == 8'h84)
      for (int n = 0; n < 4; n++) begin
        cD[n] = data[4*n+1]; cH[n] = data[4*n+2]; cE[n] = data[4*n+3];
      end
    mDone = (mDone & ~cD) | sD;
    mHalf = (mHalf & ~cH) | sH;
    mErr  = (mErr  & ~cE) | sE;
    setDone = '0; setHalf = '0; setErr = '0;
    regWrite = 1'b0; regWdata = '0;
    checkAll(tag);
  endtask

  initial begin
    enDone = '1; enHalf = '1; enErr = '1;
    repeat (3) @(posedge clk);
    #2;
    checkAll("R1 reset");
    rstN = 1'b1;
    @(posedge clk); #2;
    checkAll("R1 after release");
    enDone = '0; enHalf = '0; enErr = '0;

    // R2 R3 R4 sweep: one flag per channel and event, all enable combinations
    for (int ch = 0; ch < 4; ch++) begin
      for (int ev = 0; ev < 3; ev++) begin
        applyCycle('0, '0, '0, 1'b1, 8'h84, 32'hFFFF_FFFF, "R5 clear all");
        applyCycle(ev == 0 ? 4'(1 << ch) : 4'b0, ev == 1 ? 4'(1 << ch) : 4'b0,
                   ev == 2 ? 4'(1 << ch) : 4'b0, 1'b0, 8'h80, '0, "R2 R3 set");
        for (int en = 0; en < 8; en++) begin
          enDone = '0; enHalf = '0; enErr = '0;
          enDone[ch] = en[0]; enHalf[ch] = en[1]; enErr[ch] = en[2];
          checkAll("R4 enable sweep");
          @(posedge clk); #1;
          checkAll("R2 sticky");
        end
        enDone = '0; enHalf = '0; enErr = '0;
      end
    end

    // R5 sweep: every clear pattern on every channel over a full status word
    enDone = 4'b1010; enHalf = 4'b0110; enErr = 4'b1100;
    for (int ch = 0; ch < 4; ch++) begin
      for (int p = 0; p < 16; p++) begin
        applyCycle('1, '1, '1, 1'b0, 8'h80, '0, "R2 fill");
        applyCycle('0, '0, '0, 1'b1, 8'h84, 32'(p) << (4*ch), "R5 clear pattern");
      end
    end

    // R6: set and clear on the same flags in one cycle
    applyCycle('0, '0, '0, 1'b1, 8'h84, 32'hFFFF_FFFF, "R5 clear all");
    applyCycle(4'b0101, 4'b1000, 4'b0010, 1'b1, 8'h84, 32'hFFFF_FFFF, "R6 set wins");
    checkEq("R6 done flags", {28'b0, regRdata[13], regRdata[9], regRdata[5], regRdata[1]}, 32'h5);

    // R7: stray writes and reads
    applyCycle('0, '0, '0, 1'b1, 8'h80, 32'hFFFF_FFFF, "R7 write status ignored");
    applyCycle('0, '0, '0, 1'b1, 8'h88, 32'hFFFF_FFFF, "R7 write other ignored");
    applyCycle('0, '0, '0, 1'b1, 8'h04, 32'hFFFF_FFFF, "R7 write low ignored");
    regAddr = 8'h84; #1;
    checkEq("R7 clear reads zero", regRdata, '0);
    regAddr = 8'h88; #1;
    checkEq("R7 other reads zero", regRdata, '0);
    checkAll("R7 final");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule